// File: doc/BRIEF.md
# Serial NOR Flash Target Emulator

This block acts as the target side of a serial NOR flash bus. A host drives the serial clock, an active-low chip select and data lines. The emulator decodes an opcode byte, then an address, and serves a small on-chip byte array. Supported operations are:

- sequential read
- a write-enable latch
- page program on one line or on four lines
- sector erase
- a status byte
- a switch to four-byte addressing
- an 8-bit bank register that supplies the upper address byte in three-byte mode

The block uses bus mode 0. The host samples `so` on the rising serial clock edge, and the emulator changes `so` after each falling edge. All serial inputs are oversampled by the system clock `clk`. Each level of `sclk` must be held for at least two `clk` cycles.

After an accepted program or erase, a busy flag stays set for a fixed number of `clk` cycles. Erase walks through its sector one byte per cycle while busy is set.

Top module: `flash_emu_top`

## Requirements
- R1: Opcode 0x03, then the address (most significant byte first), returns array bytes MSB first on `so`. The address advances by one after each byte for as long as `cs_n` stays low.
- R2: After reset every byte reads 0xFF, the status byte reads 0x00 and the block is in three-byte address mode with bank register 0.
- R3: Opcode 0x06 sets the write-enable latch. A program (0x02/0x32) or erase (0x20) issued while the latch is clear leaves the array unchanged and does not set busy.
- R4: Page program 0x02 takes data bytes MSB first on `io_in[0]`. Each byte is stored as old AND new, so programming only clears bits.
- R5: Quad page program 0x32 takes its opcode and address on `io_in[0]`. Its data arrives as two 4-bit groups on `io_in[3:0]`, high group first, with `io_in[3]` as the most significant bit of each group.
- R6: During a program only the low 8 address bits advance. Data past the end of a 256-byte page wraps to the start of the same page.
- R7: Erase 0x20 sets every byte of the 2^SECT_AW-byte sector that holds the given address to 0xFF, whether or not the address is aligned. Bytes outside that sector are kept.
- R8: Opcode 0x05 returns the status byte, repeated while `cs_n` stays low: bit 0 is busy, bit 1 is the write-enable latch, and the other bits are 0.
- R9: When `cs_n` rises to end an accepted program or erase, busy is set for BUSY_CYC `clk` cycles and the write-enable latch clears. BUSY_CYC must be at least the sector size.
- R10: While busy, every opcode other than 0x05 is ignored: no latch change, no array change and `so` held low.
- R11: Opcode 0xB7 switches the address phase from three bytes to four bytes.
- R12: Opcode 0x17 followed by one byte loads the bank register, which supplies address bits 31:24 in three-byte mode. The array index is address bit 24 joined to address bits MEM_AW-2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 4 | Serial data in; bit 0 alone except during quad program data |
| so | output | 1 | Serial data out |

## Verification
The assertions check, on every cycle, these invariants:
- an array write never sets a bit that was clear;
- writes never occur while busy;
- erase steps only occur while busy;
- the program data state is only reached with the latch set;
- every accepted program or erase is followed by busy and a cleared latch.

Page wrap, sector extent, bank and four-byte address decoding, quad nibble order and the ignoring of commands while busy only appear in the data the host reads back. The bench's directed scenarios show them by programming, erasing and reading known locations.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_PROG1  = 8'h02;
    localparam logic [7:0] OP_PROG4  = 8'h32;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_ERASE  = 8'h20;
    localparam logic [7:0] OP_ADDR32 = 8'hB7;
    localparam logic [7:0] OP_BANK   = 8'h17;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_BANK,
        ST_RDATA,
        ST_PDATA,
        ST_STAT,
        ST_SKIP
    } fsm_state_e;

    typedef struct packed {
        logic [5:0] zero;
        logic       wel;
        logic       busy;
    } status_t;

    function automatic logic [7:0] assemble(input logic [6:0] held,
                                            input logic [3:0] lines,
                                            input logic       quad);
        return quad ? {held[3:0], lines} : {held, lines[0]};
    endfunction

endpackage

// File: rtl/flash_mem.sv
module flash_mem #(
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [7:0]        rd_byte,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              er_en,
    input  logic [MEM_AW-1:0] er_idx
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] cur_wr;

    assign rd_byte = mem[rd_idx];
    assign cur_wr  = mem[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (er_en) begin
            mem[er_idx] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_idx] <= cur_wr & wr_data;
        end
    end

    // R4
    and_only_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && !er_en |=> ((mem[$past(wr_idx)] & ~$past(cur_wr)) == 8'h00));

endmodule

// File: rtl/flash_busy_ctl.sv
module flash_busy_ctl #(
    parameter int MEM_AW   = 12,
    parameter int SECT_AW  = 10,
    parameter int BUSY_CYC = 1500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [MEM_AW-1:0] er_base,
    output logic              busy,
    output logic              er_en,
    output logic [MEM_AW-1:0] er_idx
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    logic [CW-1:0]             cnt;
    logic                      walking;
    logic [SECT_AW-1:0]        ptr;
    logic [MEM_AW-SECT_AW-1:0] base_hi;
    logic                      unused_base;

    assign unused_base = ^er_base[SECT_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            walking <= 1'b0;
            ptr     <= '0;
            base_hi <= '0;
        end else begin
            if (start_prog || start_erase) cnt <= CW'(BUSY_CYC);
            else if (cnt != '0)            cnt <= cnt - 1'b1;
            if (start_erase) begin
                walking <= 1'b1;
                ptr     <= '0;
                base_hi <= er_base[MEM_AW-1:SECT_AW];
            end else if (walking) begin
                ptr <= ptr + 1'b1;
                if (ptr == '1) walking <= 1'b0;
            end
        end
    end

    assign busy   = (cnt != '0);
    assign er_en  = walking;
    assign er_idx = {base_hi, ptr};

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start_prog || start_erase) |=> busy);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_emu_pkg::*;
#(
    parameter int MEM_AW  = 12,
    parameter int PAGE_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              cs_n,
    input  logic              cs_end,
    input  logic [3:0]        io_in,
    input  logic              busy,
    input  logic [7:0]        rd_byte,
    output logic [MEM_AW-1:0] rd_idx,
    output logic              wr_en,
    output logic [MEM_AW-1:0] wr_idx,
    output logic [7:0]        wr_data,
    output logic              start_prog,
    output logic              start_erase,
    output logic [MEM_AW-1:0] er_base,
    output logic              so
);
    fsm_state_e  st;
    logic [2:0]  bitcnt;
    logic [1:0]  bytecnt;
    logic [6:0]  sh;
    logic [7:0]  op, bank, out_sh, nxt;
    logic [31:0] addr, full_addr;
    logic        wel, addr4, armed, quad, byte_done, last_addr, reading;
    status_t     stat;
    logic        unused_addr;

    assign quad      = (st == ST_PDATA) && (op == OP_PROG4);
    assign nxt       = assemble(sh, io_in, quad);
    assign byte_done = quad ? (bitcnt == 3'd4) : (bitcnt == 3'd7);
    assign last_addr = (bytecnt == (addr4 ? 2'd3 : 2'd2));
    assign full_addr = addr4 ? {addr[23:0], nxt} : {bank, addr[15:0], nxt};
    assign stat      = '{zero: 6'd0, wel: wel, busy: busy};
    assign reading   = (st == ST_RDATA) || (st == ST_STAT);

    assign rd_idx      = {addr[24], addr[MEM_AW-2:0]};
    assign wr_idx      = rd_idx;
    assign er_base     = rd_idx;
    assign wr_data     = nxt;
    assign wr_en       = rise && !cs_n && (st == ST_PDATA) && byte_done;
    assign start_prog  = cs_end && armed && (op == OP_PROG1 || op == OP_PROG4);
    assign start_erase = cs_end && armed && (op == OP_ERASE);
    assign so          = reading && out_sh[7];
    assign unused_addr = ^{addr[31:25], addr[23:MEM_AW-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_OPC;  bitcnt <= '0;  bytecnt <= '0;  sh <= '0;
            op <= '0;  bank <= '0;  out_sh <= '0;  addr <= '0;
            wel <= 1'b0;  addr4 <= 1'b0;  armed <= 1'b0;
        end else if (cs_n) begin
            st <= ST_OPC;  bitcnt <= '0;  bytecnt <= '0;  armed <= 1'b0;
            if (start_prog || start_erase) wel <= 1'b0;
        end else if (rise) begin
            bitcnt <= bitcnt + (quad ? 3'd4 : 3'd1);
            sh     <= nxt[6:0];
            if (st == ST_RDATA && bitcnt == 3'd7) addr <= addr + 32'd1;
            if (byte_done) begin
                case (st)
                    ST_OPC: begin
                        op <= nxt;
                        bytecnt <= '0;
                        if (busy) st <= (nxt == OP_STATUS) ? ST_STAT : ST_SKIP;
                        else begin
                            case (nxt)
                                OP_READ, OP_PROG1, OP_PROG4, OP_ERASE: st <= ST_ADDR;
                                OP_WREN:   begin wel <= 1'b1;   st <= ST_SKIP; end
                                OP_ADDR32: begin addr4 <= 1'b1; st <= ST_SKIP; end
                                OP_BANK:   st <= ST_BANK;
                                OP_STATUS: st <= ST_STAT;
                                default:   st <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        bytecnt <= bytecnt + 2'd1;
                        addr    <= {addr[23:0], nxt};
                        if (last_addr) begin
                            addr <= full_addr;
                            if (op == OP_READ) st <= ST_RDATA;
                            else if (op == OP_ERASE) begin
                                armed <= wel;
                                st    <= ST_SKIP;
                            end else if (wel) begin
                                armed <= 1'b1;
                                st    <= ST_PDATA;
                            end else st <= ST_SKIP;
                        end
                    end
                    ST_BANK: begin
                        bank <= nxt;
                        st   <= ST_SKIP;
                    end
                    ST_PDATA: addr[PAGE_AW-1:0] <= addr[PAGE_AW-1:0] + 1'b1;
                    default: ;
                endcase
            end
        end else if (fall && reading) begin
            if (bitcnt == 3'd0) out_sh <= (st == ST_STAT) ? stat : rd_byte;
            else                out_sh <= {out_sh[6:0], 1'b0};
        end
    end

    // R3
    pdata_wel_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PDATA) |-> wel);

    // R9
    wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start_prog || start_erase) |=> !wel);

endmodule

// File: rtl/flash_emu_top.sv
module flash_emu_top #(
    parameter int MEM_AW   = 12,
    parameter int PAGE_AW  = 8,
    parameter int SECT_AW  = 10,
    parameter int BUSY_CYC = 1500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic [3:0] io_in,
    output logic       so
);
    logic              sclk_q, cs_q, rise, fall, cs_end;
    logic              busy, wr_en, er_en, start_prog, start_erase;
    logic [MEM_AW-1:0] rd_idx, wr_idx, er_idx, er_base;
    logic [7:0]        rd_byte, wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    assign rise   = sclk && !sclk_q;
    assign fall   = !sclk && sclk_q;
    assign cs_end = cs_n && !cs_q;

    flash_cmd_fsm #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_fsm (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .cs_n(cs_n),
        .cs_end(cs_end), .io_in(io_in), .busy(busy), .rd_byte(rd_byte),
        .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .start_prog(start_prog), .start_erase(start_erase),
        .er_base(er_base), .so(so)
    );

    flash_busy_ctl #(.MEM_AW(MEM_AW), .SECT_AW(SECT_AW), .BUSY_CYC(BUSY_CYC)) u_busy (
        .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
        .er_base(er_base), .busy(busy), .er_en(er_en), .er_idx(er_idx)
    );

    flash_mem #(.MEM_AW(MEM_AW)) u_mem (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_byte(rd_byte),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .er_en(er_en), .er_idx(er_idx)
    );

    // R10
    wr_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !busy);

    // R7
    erase_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        er_en |-> busy);

endmodule

// File: tb/flash_emu_top_test.sv
`timescale 1ns/1ps
module flash_emu_top_test;
    localparam int BUSY = 1500;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] io_in = 4'h0;
    logic       so;
    int         total = 0;
    int         bad = 0;
    logic       finished = 1'b0;

    flash_emu_top #(.BUSY_CYC(BUSY)) uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .io_in(io_in), .so(so)
    );

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            io_in = {3'b000, b[i]};
            tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
        end
    endtask

    task automatic send_quad(input logic [7:0] b);
        for (int h = 1; h >= 0; h--) begin
            io_in = h ? b[7:4] : b[3:0];
            tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
        end
    endtask

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(4); b[i] = so; sclk = 1'b1; tick(4); sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0; tick(4);
    endtask

    task automatic cs_high();
        tick(4); cs_n = 1'b1; tick(8);
    endtask

    task automatic send_addr(input logic [31:0] a, input bit four);
        if (four) send_byte(a[31:24]);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    endtask

    task automatic simple_cmd(input logic [7:0] op);
        cs_low(); send_byte(op); cs_high();
    endtask

    task automatic status(output logic [7:0] s);
        cs_low(); send_byte(8'h05); recv_byte(s); cs_high();
    endtask

    task automatic read1(input logic [31:0] a, input bit four, output logic [7:0] d);
        cs_low(); send_byte(8'h03); send_addr(a, four); recv_byte(d); cs_high();
    endtask

    task automatic prog1(input logic [23:0] a, input logic [7:0] d);
        cs_low(); send_byte(8'h02); send_addr({8'h00, a}, 1'b0); send_byte(d); cs_high();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        status(v);             chk("R2 R8 status after reset", v, 8'h00);
        read1(32'h000, 0, v);  chk("R2 erased byte", v, 8'hFF);
        read1(32'h3FF, 0, v);  chk("R2 erased byte high", v, 8'hFF);
    endtask

    task automatic t_gate();
        logic [7:0] v;
        prog1(24'h000100, 8'h00);
        status(v);             chk("R3 no busy without latch", v, 8'h00);
        read1(32'h100, 0, v);  chk("R3 array kept without latch", v, 8'hFF);
    endtask

    task automatic t_wrap();
        logic [7:0] v, w;
        simple_cmd(8'h06);
        status(v);             chk("R8 R3 latch visible in status", v, 8'h02);
        cs_low(); send_byte(8'h02); send_addr(32'h0000FE, 1'b0);
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56); cs_high();
        status(v);             chk("R9 busy set latch cleared", v, 8'h01);
        simple_cmd(8'h06);
        read1(32'h0FE, 0, v);  chk("R10 read ignored while busy", v, 8'h00);
        tick(BUSY + 50);
        status(v);             chk("R9 R10 idle and latch not set while busy", v, 8'h00);
        cs_low(); send_byte(8'h03); send_addr(32'h0FE, 1'b0);
        recv_byte(v); recv_byte(w); cs_high();
        chk("R4 R1 first byte", v, 8'h12);
        chk("R1 sequential byte", w, 8'h34);
        read1(32'h000, 0, v);  chk("R6 wrapped to page start", v, 8'h56);
        read1(32'h100, 0, v);  chk("R6 next page untouched", v, 8'hFF);
    endtask

    task automatic t_and();
        logic [7:0] v;
        simple_cmd(8'h06); prog1(24'h0000FE, 8'hF0); tick(BUSY + 50);
        read1(32'h0FE, 0, v);  chk("R4 program ANDs", v, 8'h10);
    endtask

    task automatic t_quad();
        logic [7:0] v, w;
        simple_cmd(8'h06);
        cs_low(); send_byte(8'h32); send_addr(32'h200, 1'b0);
        send_quad(8'hA5); send_quad(8'h3C); cs_high();
        tick(BUSY + 50);
        cs_low(); send_byte(8'h03); send_addr(32'h200, 1'b0);
        recv_byte(v); recv_byte(w); cs_high();
        chk("R5 quad first byte", v, 8'hA5);
        chk("R5 quad second byte", w, 8'h3C);
    endtask

    task automatic t_erase();
        logic [7:0] v;
        simple_cmd(8'h06); prog1(24'h000400, 8'h77); tick(BUSY + 50);
        cs_low(); send_byte(8'h20); send_addr(32'h123, 1'b0); cs_high();
        status(v);             chk("R3 erase without latch ignored", v, 8'h00);
        simple_cmd(8'h06);
        cs_low(); send_byte(8'h20); send_addr(32'h123, 1'b0); cs_high();
        status(v);             chk("R9 erase busy", v, 8'h01);
        tick(BUSY + 50);
        read1(32'h0FE, 0, v);  chk("R7 sector cleared", v, 8'hFF);
        read1(32'h000, 0, v);  chk("R7 sector start cleared", v, 8'hFF);
        read1(32'h200, 0, v);  chk("R7 sector middle cleared", v, 8'hFF);
        read1(32'h400, 0, v);  chk("R7 next sector kept", v, 8'h77);
    endtask

    task automatic t_bank();
        logic [7:0] v;
        cs_low(); send_byte(8'h17); send_byte(8'h01); cs_high();
        simple_cmd(8'h06); prog1(24'h000010, 8'h99); tick(BUSY + 50);
        cs_low(); send_byte(8'h17); send_byte(8'h00); cs_high();
        read1(32'h010, 0, v);  chk("R12 bank 0 untouched", v, 8'hFF);
        simple_cmd(8'hB7);
        read1(32'h01000010, 1, v); chk("R11 R12 four byte address bank 1", v, 8'h99);
        read1(32'h00000010, 1, v); chk("R11 four byte address bank 0", v, 8'hFF);
    endtask

    initial begin
        tick(5); rst = 1'b0; tick(5);
        t_reset();
        t_gate();
        t_wrap();
        t_and();
        t_quad();
        t_erase();
        t_bank();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule